// File: doc/BRIEF.md
# RISC Instruction Decoder and Control Generator

This block is the decode stage logic of a small 32-bit load/store style core. It takes the instruction word fetched from program memory, together with the already-incremented program counter (PC + 4). From them it produces everything the execute and writeback stages need: register specifiers, the shift amount and function code, the extended 16-bit immediate and the absolute jump target. It also produces a compact set of control signals: the ALU operation, the operand-B source, the destination register, a register-write enable, a jump flag and a link flag.

The block is purely combinational, so a pipeline register on either side sets its timing. Three instruction classes are recognised from the 6-bit opcode in bits [31:26]: register-type, immediate-type and jump-type. Any opcode or function code outside the supported set decodes to a no-op. Such an instruction writes no register and does not redirect fetch, so it cannot disturb architectural state.

Top module: `rdec_top`

## Requirements
- R1: Field outputs are taken from fixed positions of the instruction: rs = bits [25:20+1], rt = [20:16], shamt = [10:6], funct = [5:0], for every instruction word.
- R2: The class output is 0 for opcode 000000 (register-type), 2 for opcodes 000010 and 000011 (jump-type), 3 for opcodes 0100xx (reserved) and 1 for every other opcode (immediate-type).
- R3: With opcode 000000, the funct values 100001, 100011, 100100, 100101, 100110 and 100111 give ALU operation 0 (add), 1 (subtract), 2 (and), 3 (or), 4 (xor) and 5 (nor) respectively. They also give write enable 1, destination = rd (bits [15:11]) and operand-B select 0 (register).
- R4: Opcodes 001001, 001100, 001101 and 001110 give ALU operation 0, 2, 3 and 4 respectively, with operand-B select 1 (immediate), write enable 1 and destination = rt.
- R5: The 32-bit immediate output sign-extends bits [15:0] when the opcode is 001001 and zero-extends them for every other opcode.
- R6: Opcode 000010 raises the jump flag with write enable 0 and link flag 0.
- R7: Opcode 000011 raises the jump flag, the link flag and write enable, with destination 31.
- R8: The jump target output equals {PC+4 bits [31:28], instruction bits [25:0], 2'b00} for every instruction word.
- R9: Any opcode or funct value not named in R3, R4, R6 or R7 gives write enable 0, jump 0, link 0, operand-B select 0, destination 0 and ALU operation 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| pc_plus4_i | input | 32 | Address of the instruction plus 4 |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source register index |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| imm_o | output | 32 | Extended immediate |
| jump_target_o | output | 32 | Absolute jump target |
| cls_o | output | 2 | Instruction class: 0 register, 1 immediate, 2 jump, 3 reserved |
| alu_op_o | output | 3 | ALU operation select |
| use_imm_o | output | 1 | Operand-B source: 1 immediate, 0 register |
| dest_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Register-write enable |
| jump_o | output | 1 | Redirect fetch to the jump target |
| link_o | output | 1 | Write the return address to the destination |

## Verification
Immediate assertions check on every evaluation that the control outputs agree with one another. A link always implies a jump, a write to register 31 and no immediate operand. An enabled write never comes from a reserved class. The upper immediate bits are either all copies of bit 15 or all zero, and the jump target keeps the page bits of PC + 4. Whether each particular opcode and funct value maps to the right ALU code and destination can only be shown by the bench. It decodes directed encodings and random words biased toward the supported set against its own reference model, which includes near-miss funct and opcode values.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned OPC_W     = 6;
    localparam int unsigned FUNCT_W   = 6;
    localparam int unsigned REG_W     = 5;
    localparam int unsigned IMM_W     = 16;
    localparam int unsigned TGT_W     = 26;
    localparam int unsigned ALU_OP_W  = 3;
    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_NOR = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_REG = 2'd0,
        CLS_IMM = 2'd1,
        CLS_JMP = 2'd2,
        CLS_RSV = 2'd3
    } cls_e;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_J     = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;

    localparam logic [FUNCT_W-1:0] FN_ADDU = 6'b100001;
    localparam logic [FUNCT_W-1:0] FN_SUBU = 6'b100011;
    localparam logic [FUNCT_W-1:0] FN_AND  = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_XOR  = 6'b100110;
    localparam logic [FUNCT_W-1:0] FN_NOR  = 6'b100111;

    typedef struct packed {
        cls_e             cls;
        alu_op_e          alu_op;
        logic             use_imm;
        logic             reg_we;
        logic             jump;
        logic             link;
        logic [REG_W-1:0] dest;
    } ctrl_t;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
    import rdec_pkg::*;
(
    input  logic [XLEN-1:0]    instr_i,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [REG_W-1:0]   rs_o,
    output logic [REG_W-1:0]   rt_o,
    output logic [REG_W-1:0]   rd_o,
    output logic [REG_W-1:0]   shamt_o,
    output logic [FUNCT_W-1:0] funct_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [TGT_W-1:0]   tgt_o
);
    localparam int unsigned RS_LO = XLEN - OPC_W - REG_W;
    localparam int unsigned RT_LO = RS_LO - REG_W;
    localparam int unsigned RD_LO = RT_LO - REG_W;
    localparam int unsigned SA_LO = RD_LO - REG_W;

    assign opcode_o = instr_i[XLEN-1 -: OPC_W];
    assign rs_o     = instr_i[RS_LO +: REG_W];
    assign rt_o     = instr_i[RT_LO +: REG_W];
    assign rd_o     = instr_i[RD_LO +: REG_W];
    assign shamt_o  = instr_i[SA_LO +: REG_W];
    assign funct_o  = instr_i[FUNCT_W-1:0];
    assign imm_o    = instr_i[IMM_W-1:0];
    assign tgt_o    = instr_i[TGT_W-1:0];
endmodule

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    input  logic [REG_W-1:0]   rt_i,
    input  logic [REG_W-1:0]   rd_i,
    output ctrl_t              ctrl_o
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d         = '0;
        ctrl_d.alu_op  = ALU_ADD;
        // classification from opcode patterns
        if (opcode_i == OPC_REG)
            ctrl_d.cls = CLS_REG;
        else if (opcode_i[OPC_W-1:1] == OPC_J[OPC_W-1:1])
            ctrl_d.cls = CLS_JMP;
        else if (opcode_i[OPC_W-1:2] == 4'b0100)
            ctrl_d.cls = CLS_RSV;
        else
            ctrl_d.cls = CLS_IMM;

        unique case (ctrl_d.cls)
            CLS_REG: begin
                ctrl_d.reg_we = 1'b1;
                ctrl_d.dest   = rd_i;
                case (funct_i)
                    FN_ADDU: ctrl_d.alu_op = ALU_ADD;
                    FN_SUBU: ctrl_d.alu_op = ALU_SUB;
                    FN_AND:  ctrl_d.alu_op = ALU_AND;
                    FN_OR:   ctrl_d.alu_op = ALU_OR;
                    FN_XOR:  ctrl_d.alu_op = ALU_XOR;
                    FN_NOR:  ctrl_d.alu_op = ALU_NOR;
                    default: begin
                        ctrl_d.reg_we = 1'b0;
                        ctrl_d.dest   = '0;
                    end
                endcase
            end
            CLS_IMM: begin
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.use_imm = 1'b1;
                ctrl_d.dest    = rt_i;
                case (opcode_i)
                    OPC_ADDIU: ctrl_d.alu_op = ALU_ADD;
                    OPC_ANDI:  ctrl_d.alu_op = ALU_AND;
                    OPC_ORI:   ctrl_d.alu_op = ALU_OR;
                    OPC_XORI:  ctrl_d.alu_op = ALU_XOR;
                    default: begin
                        ctrl_d.reg_we  = 1'b0;
                        ctrl_d.use_imm = 1'b0;
                        ctrl_d.dest    = '0;
                    end
                endcase
            end
            CLS_JMP: begin
                ctrl_d.jump = 1'b1;
                if (opcode_i[0]) begin
                    ctrl_d.link   = 1'b1;
                    ctrl_d.reg_we = 1'b1;
                    ctrl_d.dest   = LINK_REG;
                end
            end
            default: ;
        endcase
    end

    assign ctrl_o = ctrl_d;
endmodule

// File: rtl/rdec_imm_ext.sv
module rdec_imm_ext #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 32
) (
    input  logic [IN_W-1:0]  imm_i,
    input  logic             sign_en_i,
    output logic [OUT_W-1:0] ext_o
);
    localparam int unsigned PAD_W = OUT_W - IN_W;
    logic fill;

    assign fill  = sign_en_i & imm_i[IN_W-1];
    assign ext_o = {{PAD_W{fill}}, imm_i};
endmodule

// File: rtl/rdec_jump_tgt.sv
module rdec_jump_tgt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TGT_W  = 26
) (
    input  logic [TGT_W-1:0]  tgt_i,
    input  logic [ADDR_W-1:0] pc_plus4_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int unsigned ALIGN_W = 2;
    localparam int unsigned PAGE_W  = ADDR_W - TGT_W - ALIGN_W;

    assign target_o = {pc_plus4_i[ADDR_W-1 -: PAGE_W], tgt_i, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/rdec_top.sv
module rdec_top
    import rdec_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] pc_plus4_i,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  shamt_o,
    output logic [5:0]  funct_o,
    output logic [31:0] imm_o,
    output logic [31:0] jump_target_o,
    output logic [1:0]  cls_o,
    output logic [2:0]  alu_op_o,
    output logic        use_imm_o,
    output logic [4:0]  dest_o,
    output logic        reg_we_o,
    output logic        jump_o,
    output logic        link_o
);
    logic [OPC_W-1:0]   opcode;
    logic [REG_W-1:0]   rd;
    logic [IMM_W-1:0]   imm_raw;
    logic [TGT_W-1:0]   tgt_raw;
    ctrl_t              ctrl;

    rdec_fields u_fields (
        .instr_i  (instr_i),
        .opcode_o (opcode),
        .rs_o     (rs_o),
        .rt_o     (rt_o),
        .rd_o     (rd),
        .shamt_o  (shamt_o),
        .funct_o  (funct_o),
        .imm_o    (imm_raw),
        .tgt_o    (tgt_raw)
    );

    rdec_ctrl u_ctrl (
        .opcode_i (opcode),
        .funct_i  (funct_o),
        .rt_i     (rt_o),
        .rd_i     (rd),
        .ctrl_o   (ctrl)
    );

    rdec_imm_ext #(.IN_W(IMM_W), .OUT_W(XLEN)) u_imm (
        .imm_i     (imm_raw),
        .sign_en_i (opcode == OPC_ADDIU),
        .ext_o     (imm_o)
    );

    rdec_jump_tgt #(.ADDR_W(XLEN), .TGT_W(TGT_W)) u_jmp (
        .tgt_i      (tgt_raw),
        .pc_plus4_i (pc_plus4_i),
        .target_o   (jump_target_o)
    );

    assign cls_o     = ctrl.cls;
    assign alu_op_o  = ctrl.alu_op;
    assign use_imm_o = ctrl.use_imm;
    assign dest_o    = ctrl.dest;
    assign reg_we_o  = ctrl.reg_we;
    assign jump_o    = ctrl.jump;
    assign link_o    = ctrl.link;

    // cross-checks between separately driven outputs
    always_comb begin
        a_r7_link_consistent: assert (!link_o || (jump_o && reg_we_o && dest_o == LINK_REG && !use_imm_o))
            else $error("R7 link without jump/write to r31");
        a_r9_no_write_reserved: assert (!(reg_we_o && cls_o == CLS_RSV))
            else $error("R9 write enabled for reserved class");
        a_r9_quiet_when_idle: assert (reg_we_o || jump_o || (dest_o == '0 && !use_imm_o && alu_op_o == ALU_ADD))
            else $error("R9 no-op carries nonzero control");
        a_r5_ext_uniform: assert (imm_o[31:16] == '0 || imm_o[31:16] == {16{imm_o[15]}})
            else $error("R5 immediate upper bits malformed");
        a_r8_page_kept: assert (jump_target_o[31:28] == pc_plus4_i[31:28] && jump_target_o[1:0] == 2'b00)
            else $error("R8 jump target page or alignment wrong");
        a_r4_imm_means_itype: assert (!use_imm_o || (cls_o == CLS_IMM && reg_we_o && dest_o == rt_o))
            else $error("R4 immediate operand outside supported immediate-type");
    end
endmodule

// File: tb/tb_rdec_top.sv
`timescale 1ns/1ps
module tb_rdec_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] instr, pc4;
    logic [4:0]  rs, rt, shamt, dest;
    logic [5:0]  funct;
    logic [31:0] imm, jtgt;
    logic [1:0]  cls;
    logic [2:0]  alu_op;
    logic        use_imm, we, jmp, lnk;

    int n_tests = 0;
    int n_fail  = 0;

    rdec_top dut (
        .instr_i(instr), .pc_plus4_i(pc4),
        .rs_o(rs), .rt_o(rt), .shamt_o(shamt), .funct_o(funct),
        .imm_o(imm), .jump_target_o(jtgt), .cls_o(cls), .alu_op_o(alu_op),
        .use_imm_o(use_imm), .dest_o(dest), .reg_we_o(we),
        .jump_o(jmp), .link_o(lnk)
    );

    typedef struct packed {
        logic [1:0] cls;
        logic [2:0] op;
        logic       ui;
        logic       we;
        logic       j;
        logic       l;
        logic [4:0] dst;
    } exp_t;

    function automatic exp_t model(input logic [31:0] w);
        exp_t e = '0;
        logic [5:0] opc = w[31:26];
        logic [5:0] fn  = w[5:0];
        if (opc == 6'd0)               e.cls = 2'd0;
        else if (opc[5:1] == 5'b00001) e.cls = 2'd2;
        else if (opc[5:2] == 4'b0100)  e.cls = 2'd3;
        else                           e.cls = 2'd1;
        if (opc == 6'd0) begin
            e.we = 1'b1; e.dst = w[15:11];
            case (fn)
                6'b100001: e.op = 3'd0;
                6'b100011: e.op = 3'd1;
                6'b100100: e.op = 3'd2;
                6'b100101: e.op = 3'd3;
                6'b100110: e.op = 3'd4;
                6'b100111: e.op = 3'd5;
                default: begin e.we = 1'b0; e.dst = 5'd0; end
            endcase
        end else begin
            e.we = 1'b1; e.ui = 1'b1; e.dst = w[20:16];
            case (opc)
                6'b001001: e.op = 3'd0;
                6'b001100: e.op = 3'd2;
                6'b001101: e.op = 3'd3;
                6'b001110: e.op = 3'd4;
                6'b000010: begin e.we = 1'b0; e.ui = 1'b0; e.dst = 5'd0; e.j = 1'b1; end
                6'b000011: begin e.ui = 1'b0; e.dst = 5'd31; e.j = 1'b1; e.l = 1'b1; end
                default:   begin e.we = 1'b0; e.ui = 1'b0; e.dst = 5'd0; end
            endcase
        end
        return e;
    endfunction

    function automatic logic [31:0] model_imm(input logic [31:0] w);
        if (w[31:26] == 6'b001001) return {{16{w[15]}}, w[15:0]};
        return {16'd0, w[15:0]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%h pc4=%h act=%h exp=%h", req, instr, pc4, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] p);
        exp_t e;
        @(posedge clk);
        instr = w; pc4 = p;
        @(negedge clk);
        e = model(w);
        chk("R1 fields", {rs, rt, shamt, funct}, {w[25:21], w[20:16], w[10:6], w[5:0]});
        chk("R2 class", cls, e.cls);
        if (w[31:26] == 6'd0)
            chk("R3 reg-type ctrl", {alu_op, use_imm, we, dest}, {e.op, e.ui, e.we, e.dst});
        else
            chk("R4 imm-type ctrl", {alu_op, use_imm, we, dest}, {e.op, e.ui, e.we, e.dst});
        chk("R5 immediate", imm, model_imm(w));
        chk("R6 R7 jump/link", {jmp, lnk, we, dest}, {e.j, e.l, e.we, e.dst});
        chk("R8 jump target", jtgt, {p[31:28], w[25:0], 2'b00});
        if (!e.we && !e.j)
            chk("R9 no-op", {we, jmp, lnk, use_imm, dest, alu_op}, 15'd0);
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w = $urandom;
        int sel = $urandom_range(0, 9);
        logic [5:0] fl [6] = '{6'b100001, 6'b100011, 6'b100100, 6'b100101, 6'b100110, 6'b100111};
        logic [5:0] ol [4] = '{6'b001001, 6'b001100, 6'b001101, 6'b001110};
        if (sel < 4) begin
            w[31:26] = 6'd0;
            if ($urandom_range(0, 9) < 7) w[5:0] = fl[$urandom_range(0, 5)];
        end else if (sel == 4) begin
            w[31:26] = {5'b00001, 1'($urandom_range(0, 1))};
        end else if (sel < 8) begin
            w[31:26] = ol[$urandom_range(0, 3)];
        end
        return w;
    endfunction

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        instr = '0; pc4 = '0;
        void'($urandom(32'h1A2B3C4D));
        @(negedge clk);
        // idle state: all-zero word is register-type with unsupported funct (R9)
        chk("R9 idle zero word", {we, jmp, lnk, use_imm, dest}, 9'd0);
        // R3 each funct
        apply(32'h0043_2821, 32'h0000_0004); // addu r5,r2,r3
        apply(32'h0043_2823, 32'h0);
        apply(32'h0043_2824, 32'h0);
        apply(32'h0043_2825, 32'h0);
        apply(32'h0043_2826, 32'h0);
        apply(32'h0043_2827, 32'h0);
        apply(32'h0043_2820, 32'h0);          // R9 near-miss funct (signed add)
        apply(32'h0043_2822, 32'h0);          // R9 near-miss funct
        // R4 / R5 immediates with sign bit set and clear
        apply(32'h2422_8001, 32'h0);          // addiu: sign-extended
        apply(32'h2422_7FFF, 32'h0);
        apply(32'h3022_8001, 32'h0);          // andi: zero-extended
        apply(32'h3422_FFFF, 32'h0);          // ori
        apply(32'h3822_8000, 32'h0);          // xori
        apply(32'h2022_8000, 32'h0);          // R9 opcode 001000 unsupported
        apply(32'h3C22_8000, 32'h0);          // R9 opcode 001111 unsupported
        // R2 reserved class 0100xx
        apply(32'h4000_0000, 32'h0);
        apply(32'h4FFF_FFFF, 32'h0);
        // R6 R7 R8 jumps with various PC pages
        apply(32'h0BFF_FFFF, 32'hF000_0004);
        apply(32'h0C00_0001, 32'hA123_4568);
        apply(32'h0E00_0000, 32'h1FFF_FFFC);
        for (int i = 0; i < 3000; i++)
            apply(rnd_word(), $urandom);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule